// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It frees the bus when a slave has been left in the middle of a byte after an aborted transfer, a power glitch or a reset and is still pulling the data line low. A recovery request makes the sequencer toggle the clock line. Each pulse has a low phase followed by a high phase. At the end of every high phase the sequencer looks at the data line. It stops clocking at the first high phase in which the data line reads released, and it gives up after a fixed maximum number of pulses.

Once the data line is free, the sequencer drives a start condition and then a stop condition. This leaves every slave with a reset protocol state and leaves the bus idle with both lines released. It then holds the bus free for the minimum idle time and raises `done`. When the data line never came free, it raises `fail` along with `done`. Both lines are open-drain: an output enable of 1 pulls the line low and 0 releases it. The durations of all phases are counters computed from a clock-frequency parameter and a set of nanosecond minimums. The data-line input may pass through an optional synchronizer.

Top module: `bus_recover`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `done` and `fail` are all 0. An enable of 1 pulls its line low and 0 releases it.
- R2: A `recover_req` sampled high while idle or done starts a recovery. In the next cycle `scl_oe` is 1 and `done` and `fail` are 0.
- R3: Every clock low phase (`scl_oe`=1) lasts at least ceil(CLK_MHZ*T_LOW_NS/1000) cycles, which is 240 at the defaults.
- R4: Every clock high phase between two pulses lasts at least ceil(CLK_MHZ*T_HIGH_NS/1000) cycles, which is 120 at the defaults.
- R5: The data line is sampled at the end of each high phase. Clocking stops after the first high phase in which it reads 1, so the number of pulses equals the index of that phase.
- R6: At most MAX_PULSES pulses (default 9) are issued. If the data line is still 0 at the end of the last high phase, no start or stop is driven, both lines stay released, and `done`=1 with `fail`=1.
- R7: The start condition sets `sda_oe` to 1 only while `scl_oe` is 0, after the clock line has been released for at least the start setup time (120 cycles).
- R8: The data line is held low with the clock released for at least the start hold time plus the stop setup time (240 cycles). It is then released, which makes the stop condition.
- R9: `done` rises only after both lines have been free for at least the bus free time (240 cycles) following the stop. `done` and `fail` then hold until the next accepted request, and `fail`=0 after a successful recovery.
- R10: A `recover_req` that arrives while a recovery is running is ignored. The pulse count and the single rise of `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | Start a recovery sequence (sampled when idle or done) |
| sda_in | input | 1 | Level of the data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | Sequence finished; held until the next request |
| fail | output | 1 | With done: the data line never came free |

## Verification
The only result with a fixed latency is the first clock low, which appears in the cycle after the request is sampled. The bench checks it at the very next falling edge of the clock, together with the clearing of `done` and `fail`. Every later result depends on how long the slave keeps the data line low. So a monitor sampling at falling edges measures the run length of each phase, counts pulses, and records start, stop and free time. The checks run once `done` has risen, and they compare these measurements against minimum cycle counts computed in the bench from the nanosecond limits and the 200 MHz clock.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_SU_STA,
      ST_HD_STA,
      ST_SU_STO,
      ST_BUF,
      ST_DONE
   } brs_state_t;

   // Whole cycles covering a time in ns at a clock in MHz (rounded up, at least 1)
   function automatic int unsigned ns_to_cyc(input int unsigned mhz, input int unsigned ns);
      int unsigned c;
      c = (mhz * ns + 999) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d_in;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign d_out = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/brs_timer.sv
module brs_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
   import brs_pkg::*;
#(
   parameter int TW         = 8,
   parameter int MAX_PULSES = 9,
   parameter int C_LOW      = 240,
   parameter int C_HIGH     = 120,
   parameter int C_SU_STA   = 120,
   parameter int C_HD_STA   = 120,
   parameter int C_SU_STO   = 120,
   parameter int C_BUF      = 240
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          sda_s,
   input  logic          tmr_exp,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          scl_oe,
   output logic          sda_oe,
   output logic          done,
   output logic          fail
);
   localparam int PW = $clog2(MAX_PULSES + 1);

   brs_state_t    st, nxt;
   logic [PW-1:0] pcnt;
   logic          fail_q, fail_set, accept;

   assign accept = ((st == ST_IDLE) || (st == ST_DONE)) && req;

   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      fail_set = 1'b0;
      unique case (st)
         ST_IDLE, ST_DONE: begin
            if (req) begin
               nxt = ST_LOW; tmr_load = 1'b1; tmr_val = TW'(C_LOW - 1);
            end
         end
         ST_LOW: begin
            if (tmr_exp) begin
               nxt = ST_HIGH; tmr_load = 1'b1; tmr_val = TW'(C_HIGH - 1);
            end
         end
         ST_HIGH: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               if (sda_s) begin
                  nxt = ST_SU_STA; tmr_val = TW'(C_SU_STA - 1);
               end else if (pcnt == PW'(MAX_PULSES)) begin
                  nxt = ST_BUF; tmr_val = TW'(C_BUF - 1); fail_set = 1'b1;
               end else begin
                  nxt = ST_LOW; tmr_val = TW'(C_LOW - 1);
               end
            end
         end
         ST_SU_STA: begin
            if (tmr_exp) begin
               nxt = ST_HD_STA; tmr_load = 1'b1; tmr_val = TW'(C_HD_STA - 1);
            end
         end
         ST_HD_STA: begin
            if (tmr_exp) begin
               nxt = ST_SU_STO; tmr_load = 1'b1; tmr_val = TW'(C_SU_STO - 1);
            end
         end
         ST_SU_STO: begin
            if (tmr_exp) begin
               nxt = ST_BUF; tmr_load = 1'b1; tmr_val = TW'(C_BUF - 1);
            end
         end
         ST_BUF: begin
            if (tmr_exp) nxt = ST_DONE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         pcnt   <= '0;
         fail_q <= 1'b0;
      end else begin
         st <= nxt;
         if (accept)                                pcnt <= PW'(1);
         else if ((st == ST_HIGH) && (nxt == ST_LOW)) pcnt <= pcnt + 1'b1;
         if (accept)        fail_q <= 1'b0;
         else if (fail_set) fail_q <= 1'b1;
      end
   end

   assign scl_oe = (st == ST_LOW);
   assign sda_oe = (st == ST_HD_STA) || (st == ST_SU_STO);
   assign done   = (st == ST_DONE);
   assign fail   = fail_q && (st == ST_DONE);
endmodule

// File: rtl/bus_recover.sv
module bus_recover
   import brs_pkg::*;
#(
   parameter int CLK_MHZ     = 200,
   parameter int MAX_PULSES  = 9,
   parameter int SYNC_STAGES = 2,
   parameter int T_LOW_NS    = 1200,
   parameter int T_HIGH_NS   = 600,
   parameter int T_SU_STA_NS = 600,
   parameter int T_HD_STA_NS = 600,
   parameter int T_SU_STO_NS = 600,
   parameter int T_BUF_NS    = 1200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic done,
   output logic fail
);
   localparam int LOW_CYC    = int'(ns_to_cyc(CLK_MHZ, T_LOW_NS));
   localparam int HIGH_CYC   = int'(ns_to_cyc(CLK_MHZ, T_HIGH_NS));
   localparam int SU_STA_CYC = int'(ns_to_cyc(CLK_MHZ, T_SU_STA_NS));
   localparam int HD_STA_CYC = int'(ns_to_cyc(CLK_MHZ, T_HD_STA_NS));
   localparam int SU_STO_CYC = int'(ns_to_cyc(CLK_MHZ, T_SU_STO_NS));
   localparam int BUF_CYC    = int'(ns_to_cyc(CLK_MHZ, T_BUF_NS));
   localparam int MAX_A      = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int MAX_B      = (SU_STA_CYC > HD_STA_CYC) ? SU_STA_CYC : HD_STA_CYC;
   localparam int MAX_C      = (SU_STO_CYC > BUF_CYC) ? SU_STO_CYC : BUF_CYC;
   localparam int MAX_AB     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CYC    = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
   localparam int TW         = $clog2(MAX_CYC + 1);

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("bus_recover: CLK_MHZ must be at least 1");
      end
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("bus_recover: MAX_PULSES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("bus_recover: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic          sda_s;
   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;

   brs_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .d_out(sda_s)
   );

   brs_timer #(.TW(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   brs_fsm #(
      .TW(TW), .MAX_PULSES(MAX_PULSES),
      .C_LOW(LOW_CYC), .C_HIGH(HIGH_CYC), .C_SU_STA(SU_STA_CYC),
      .C_HD_STA(HD_STA_CYC), .C_SU_STO(SU_STO_CYC), .C_BUF(BUF_CYC)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .req(recover_req), .sda_s(sda_s),
      .tmr_exp(tmr_exp), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .fail(fail)
   );
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
   parameter int T_LOW      = 240,
   parameter int T_HIGH     = 120,
   parameter int T_SU_STA   = 120,
   parameter int T_HOLD_STO = 240,
   parameter int MAX_PULSES = 9
) (
   input logic clk,
   input logic rst_n,
   input logic scl_oe,
   input logic sda_oe,
   input logic done,
   input logic fail
);
   localparam int unsigned SAT = 32'hFFFF_FFF0;

   int unsigned lo_len, hi_len, sda_len, pc;
   logic        had_pulse, scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_len    <= 0;
         hi_len    <= 0;
         sda_len   <= 0;
         pc        <= 0;
         had_pulse <= 1'b0;
         scl_q     <= 1'b0;
      end else begin
         scl_q   <= scl_oe;
         lo_len  <= scl_oe ? ((lo_len < SAT) ? lo_len + 1 : lo_len) : 0;
         hi_len  <= !scl_oe ? ((hi_len < SAT) ? hi_len + 1 : hi_len) : 0;
         sda_len <= sda_oe ? ((sda_len < SAT) ? sda_len + 1 : sda_len) : 0;
         if (done)        had_pulse <= 1'b0;
         else if (scl_oe) had_pulse <= 1'b1;
         if (done)                     pc <= 0;
         else if (scl_oe && !scl_q && pc < SAT) pc <= pc + 1;
      end
   end

   p_low_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |-> (lo_len >= T_LOW));

   p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_oe) && had_pulse) |-> (hi_len >= T_HIGH));

   p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= MAX_PULSES);

   p_fail_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!scl_oe && !sda_oe));

   p_start_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> !scl_oe);

   p_start_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> (hi_len >= T_SU_STA));

   p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (sda_len >= T_HOLD_STO));

   p_fail_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);

   p_done_until_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> scl_oe);
endmodule

bind bus_recover brs_chk #(
   .T_LOW(LOW_CYC),
   .T_HIGH(HIGH_CYC),
   .T_SU_STA(SU_STA_CYC),
   .T_HOLD_STO(HD_STA_CYC + SU_STO_CYC),
   .MAX_PULSES(MAX_PULSES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .done(done), .fail(fail)
);

// File: tb/test_bus_recover.sv
`timescale 1ns/1ps
module test_bus_recover;
   localparam int MHZ      = 200;
   localparam int E_LOW    = (MHZ * 1200 + 999) / 1000;
   localparam int E_HIGH   = (MHZ * 600 + 999) / 1000;
   localparam int E_SU     = (MHZ * 600 + 999) / 1000;
   localparam int E_HOLD   = 2 * ((MHZ * 600 + 999) / 1000);
   localparam int E_BUF    = (MHZ * 1200 + 999) / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recover_req = 1'b0;
   logic sda_in;
   logic scl_oe, sda_oe, done, fail;

   int errors = 0;
   int checks = 0;
   int k_hold = 0;

   int clr_tok = 0, clr_seen = 0;
   int pulses, min_low, min_high, starts, stops, su_sta, sda_len, buf_len;
   int lo_run, hi_run, sda_run, free_run, done_rises;
   logic start_ok, stop_ok, bad_scl, after_stop;
   logic p_scl = 1'b0, p_sda = 1'b0, p_done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_in = !sda_oe && !(pulses < k_hold);

   bus_recover i_bus_recover (
      .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .fail(fail)
   );

   initial begin
      pulses = 0; min_low = 1 << 30; min_high = 1 << 30; starts = 0; stops = 0;
      su_sta = 0; sda_len = 0; buf_len = 0; lo_run = 0; hi_run = 0; sda_run = 0;
      free_run = 0; done_rises = 0; start_ok = 0; stop_ok = 0; bad_scl = 0; after_stop = 0;
   end

   always @(negedge clk) begin
      if (clr_tok != clr_seen) begin
         clr_seen = clr_tok;
         pulses = 0; min_low = 1 << 30; min_high = 1 << 30; starts = 0; stops = 0;
         su_sta = 0; sda_len = 0; buf_len = 0; lo_run = 0; hi_run = 0; sda_run = 0;
         free_run = 0; done_rises = 0; start_ok = 0; stop_ok = 0; bad_scl = 0;
         after_stop = 0;
      end else begin
         if (sda_oe && !p_sda) begin
            starts++;
            if (!scl_oe) start_ok = 1'b1;
            su_sta = hi_run;
         end
         if (sda_oe) begin
            sda_run++;
            if (scl_oe) bad_scl = 1'b1;
         end else if (p_sda) begin
            stops++;
            if (!scl_oe) stop_ok = 1'b1;
            sda_len = sda_run;
            sda_run = 0;
            free_run = 0;
            after_stop = 1'b1;
         end
         if (scl_oe) begin
            if (!p_scl) begin
               if (pulses > 0 && hi_run < min_high) min_high = hi_run;
               pulses++;
            end
            lo_run++;
            hi_run = 0;
         end else begin
            if (p_scl && lo_run < min_low) min_low = lo_run;
            lo_run = 0;
            hi_run++;
         end
         if (done && !p_done) begin
            done_rises++;
            buf_len = free_run;
         end
         if (after_stop && !done && !scl_oe && !sda_oe) free_run++;
      end
      p_scl = scl_oe; p_sda = sda_oe; p_done = done;
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_ge(input string tag, input int act, input int lim);
      checks++;
      if (act < lim) begin
         errors++;
         $display("FAIL %s: actual=%0d expected>=%0d", tag, act, lim);
      end
   endtask

   // One recovery: slave releases the data line at the k-th clock fall.
   task automatic run_case(input int k, input int exp_pulses, input logic exp_fail,
                           input int extra_req_at);
      int waited;
      @(posedge clk);
      clr_tok++;
      k_hold = k;
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      recover_req = 1'b0;
      check_eq("R2 scl_oe after request", int'(scl_oe), 1);
      check_eq("R2 done cleared", int'(done), 0);
      check_eq("R2 fail cleared", int'(fail), 0);
      waited = 0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
         if (waited == extra_req_at) recover_req = 1'b1;
         else recover_req = 1'b0;
      end
      recover_req = 1'b0;
      repeat (20) @(negedge clk);
      check_eq("R9 done level held", int'(done), 1);
      check_eq("R10 single done rise", done_rises, 1);
      check_eq("R5 pulse count", pulses, exp_pulses);
      check_eq("R6 fail flag", int'(fail), int'(exp_fail));
      check_ge("R3 min low phase", min_low, E_LOW);
      if (exp_pulses > 1) check_ge("R4 min high phase", min_high, E_HIGH);
      check_eq("R7 scl low while sda driven", int'(bad_scl), 0);
      check_eq("R6 lines released at end", int'(scl_oe) + int'(sda_oe), 0);
      if (exp_fail) begin
         check_eq("R6 no start on fail", starts, 0);
      end else begin
         check_eq("R7 one start", starts, 1);
         check_eq("R7 start with scl high", int'(start_ok), 1);
         check_ge("R7 start setup", su_sta, E_SU);
         check_eq("R8 stop with scl high", int'(stop_ok), 1);
         check_ge("R8 sda low time", sda_len, E_HOLD);
         check_ge("R9 bus free before done", buf_len, E_BUF);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check_eq("R1 scl_oe reset", int'(scl_oe), 0);
      check_eq("R1 sda_oe reset", int'(sda_oe), 0);
      check_eq("R1 done reset", int'(done), 0);
      check_eq("R1 fail reset", int'(fail), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_eq("R1 idle after reset", int'(scl_oe) + int'(sda_oe) + int'(done), 0);

      run_case(0, 1, 1'b0, 0);      // bus already free: one pulse
      run_case(4, 4, 1'b0, 0);      // released mid-sequence
      run_case(10, 9, 1'b1, 0);     // never frees: fail after the cap
      run_case(9, 9, 1'b0, 0);      // frees on the last allowed pulse
      run_case(4, 4, 1'b0, 700);    // R10: request while running is ignored
      run_case(1000, 9, 1'b1, 300); // stuck for good, plus ignored request

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule